// File: doc/BRIEF.md
# Flash Block Protection Manager

This block holds the protection state for the erase blocks of a flash device: one lock bit per block and a global write-protect flag. The command interface hands it already decoded protection commands (lock a block, turn write protection on, turn it off, erase every unlocked block). The block answers each write or erase request with a one-cycle grant or reject pulse. The command interface turns a reject into the matching status error bit.

A stored lock only takes effect while write protection is on. Turning protection off opens every block, and turning it back on brings the stored locks back into force. A granted erase of a block clears that block's lock. The erase-all command starts a walk over the blocks in ascending order. The walk issues one erase pulse per block it may erase, skips blocks that are locked and protected, and flags the last step.

Top module: `flash_lock_guard`

## Requirements
- R1: After reset no block is locked, write protection is off, the walk is idle and neither grant nor reject is asserted.
- R2: A request sampled on a clock edge produces exactly one of a grant or a reject pulse, visible after that same edge. A cycle without a request produces neither.
- R3: The block index is the top five bits of the 19-bit byte address, so each block spans 16 KB.
- R4: With write protection on, a write (reqErase=0) or an erase (reqErase=1) aimed at a locked block is rejected. Requests to unlocked blocks are granted.
- R5: While write protection is off (op code 2 applied), every request is granted whether or not the block is locked.
- R6: Turning write protection on (op code 1) makes the locks stored earlier take effect again. Op code 0 locks the addressed block.
- R7: A granted erase clears the lock of its block. A rejected erase leaves the lock set.
- R8: Op code 3 starts a walk that visits every block once, in ascending order. It emits one erase pulse, with the block index, per block that is not both locked and protected. A done pulse comes with the step for the last block, and busy is high from the edge after the command until that step.
- R9: Each block erased by the walk has its lock cleared. Skipped blocks keep their locks. With protection off, all 32 blocks are erased.
- R10: While the walk is busy, every request is rejected and every command is ignored.
- R11: When a lock command and a granted erase target the same block in the same cycle, the erase is judged on the state before that cycle, and the block ends up locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Decoded protection command present |
| cmdOp | input | 2 | 0 lock block, 1 protection on, 2 protection off, 3 erase all unlocked |
| cmdAddr | input | 19 | Byte address naming the block for a lock command |
| reqValid | input | 1 | Write or erase permission query present |
| reqErase | input | 1 | 1 for erase, 0 for write |
| reqAddr | input | 19 | Byte address of the query |
| reqGrant | output | 1 | Query allowed (one-cycle pulse) |
| reqReject | output | 1 | Query denied (one-cycle pulse) |
| walkErase | output | 1 | Walk erase pulse for walkBlk |
| walkBlk | output | 5 | Block index of the current walk step |
| walkDone | output | 1 | Pulse with the final walk step |
| walkBusy | output | 1 | Walk in progress |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a lock command and a granted erase of the same block. The bench drives both in one cycle and judges the result by the grant for the erase and a rejected write to that block afterwards. The second pair is the walk and outside traffic. The bench issues a request and a lock command to a free block while the walk runs. It expects a reject for the request. It checks that the lock was ignored through a granted write to that block after the walk. It also checks that the erase pulse pattern is unchanged.

// File: rtl/lock_guard_pkg.sv
package lock_guard_pkg;

  typedef enum logic [1:0] {
    OP_LOCK_BLK  = 2'd0,
    OP_WP_ON     = 2'd1,
    OP_WP_OFF    = 2'd2,
    OP_ERASE_ALL = 2'd3
  } guard_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_state_e;

  // strobes from the control to the protection store
  typedef struct packed {
    logic lockSet;
    logic lockClrReq;
    logic lockClrWalk;
    logic wpSet;
    logic wpClr;
  } guard_stb_t;

endpackage

// File: rtl/lock_store.sv
module lock_store
  import lock_guard_pkg::*;
#(
  parameter int BLK_CNT = 32,
  localparam int BLK_W = $clog2(BLK_CNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  guard_stb_t       stb,
  input  logic [BLK_W-1:0] cmdBlk,
  input  logic [BLK_W-1:0] reqBlk,
  input  logic [BLK_W-1:0] walkIdx,
  output logic             reqBlocked,
  output logic             walkBlocked,
  output logic             wpOn
);

  logic [BLK_CNT-1:0] lockVec;

  always_ff @(posedge clk) begin
    if (!rstN)          wpOn <= 1'b0;
    else if (stb.wpSet) wpOn <= 1'b1;
    else if (stb.wpClr) wpOn <= 1'b0;
  end

  // one lock bit per block; a set in the same cycle beats a clear
  for (genvar g = 0; g < BLK_CNT; g++) begin : g_lock
    logic hitSet, hitClr;
    assign hitSet = stb.lockSet && (cmdBlk == BLK_W'(g));
    assign hitClr = (stb.lockClrReq && (reqBlk == BLK_W'(g))) ||
                    (stb.lockClrWalk && (walkIdx == BLK_W'(g)));
    always_ff @(posedge clk) begin
      if (!rstN)       lockVec[g] <= 1'b0;
      else if (hitSet) lockVec[g] <= 1'b1;
      else if (hitClr) lockVec[g] <= 1'b0;
    end
  end

  assign reqBlocked  = wpOn && lockVec[reqBlk];
  assign walkBlocked = wpOn && lockVec[walkIdx];

endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_guard_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int BLK_CNT = 32,
  localparam int BLK_W = $clog2(BLK_CNT),
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(BLK_CNT - 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              reqValid,
  input  logic              reqErase,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqBlocked,
  input  logic              walkBlocked,
  output guard_stb_t        stb,
  output logic [BLK_W-1:0]  cmdBlk,
  output logic [BLK_W-1:0]  reqBlk,
  output logic [BLK_W-1:0]  walkIdx,
  output logic              reqGrant,
  output logic              reqReject,
  output logic              walkErase,
  output logic [BLK_W-1:0]  walkBlk,
  output logic              walkDone,
  output logic              walkBusy
);

  walk_state_e state;
  guard_op_e   op;
  logic        idle;

  assign op     = guard_op_e'(cmdOp);
  assign idle   = (state == ST_IDLE);
  assign cmdBlk = cmdAddr[ADDR_W-1 -: BLK_W];
  assign reqBlk = reqAddr[ADDR_W-1 -: BLK_W];
  assign walkBusy = !idle;

  always_comb begin
    stb = '0;
    if (idle && cmdValid) begin
      case (op)
        OP_LOCK_BLK: stb.lockSet = 1'b1;
        OP_WP_ON:    stb.wpSet   = 1'b1;
        OP_WP_OFF:   stb.wpClr   = 1'b1;
        default:     ;
      endcase
    end
    stb.lockClrReq  = idle && reqValid && reqErase && !reqBlocked;
    stb.lockClrWalk = !idle && !walkBlocked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      walkIdx   <= '0;
      reqGrant  <= 1'b0;
      reqReject <= 1'b0;
      walkErase <= 1'b0;
      walkBlk   <= '0;
      walkDone  <= 1'b0;
    end else begin
      reqGrant  <= reqValid && idle && !reqBlocked;
      reqReject <= reqValid && (!idle || reqBlocked);
      walkErase <= !idle && !walkBlocked;
      walkDone  <= !idle && (walkIdx == LAST_BLK);
      if (!idle) walkBlk <= walkIdx;
      case (state)
        ST_IDLE: begin
          if (cmdValid && op == OP_ERASE_ALL) begin
            state   <= ST_WALK;
            walkIdx <= '0;
          end
        end
        ST_WALK: begin
          if (walkIdx == LAST_BLK) state <= ST_IDLE;
          else walkIdx <= walkIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_lock_guard.sv
module flash_lock_guard
  import lock_guard_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int BLK_CNT = 32,
  localparam int BLK_W = $clog2(BLK_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              reqValid,
  input  logic              reqErase,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqGrant,
  output logic              reqReject,
  output logic              walkErase,
  output logic [BLK_W-1:0]  walkBlk,
  output logic              walkDone,
  output logic              walkBusy
);

  guard_stb_t       stb;
  logic [BLK_W-1:0] cmdBlk, reqBlk, walkIdx;
  logic             reqBlocked, walkBlocked, wpOn;

  lock_ctrl #(.ADDR_W(ADDR_W), .BLK_CNT(BLK_CNT)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .reqValid(reqValid), .reqErase(reqErase), .reqAddr(reqAddr),
    .reqBlocked(reqBlocked), .walkBlocked(walkBlocked),
    .stb(stb), .cmdBlk(cmdBlk), .reqBlk(reqBlk), .walkIdx(walkIdx),
    .reqGrant(reqGrant), .reqReject(reqReject),
    .walkErase(walkErase), .walkBlk(walkBlk),
    .walkDone(walkDone), .walkBusy(walkBusy)
  );

  lock_store #(.BLK_CNT(BLK_CNT)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cmdBlk(cmdBlk), .reqBlk(reqBlk), .walkIdx(walkIdx),
    .reqBlocked(reqBlocked), .walkBlocked(walkBlocked), .wpOn(wpOn)
  );

endmodule

// File: rtl/lock_guard_chk.sv
module lock_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic       reqValid,
  input logic       reqGrant,
  input logic       reqReject,
  input logic       walkErase,
  input logic       walkDone,
  input logic       walkBusy,
  input logic       wpOn
);

  p_one_answer_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (reqGrant ^ reqReject));

  p_no_answer_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(reqGrant || reqReject));

  p_open_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !walkBusy && !wpOn) |=> reqGrant);

  p_wp_on_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd1 && !walkBusy) |=> wpOn);

  p_erase_in_walk_r8: assert property (@(posedge clk) disable iff (!rstN)
    walkErase |-> (walkBusy || walkDone));

  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    walkDone |-> !walkBusy);

  p_busy_reject_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && walkBusy) |=> reqReject);

  p_cmd_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && walkBusy) |=> $stable(wpOn));

endmodule

bind flash_lock_guard lock_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .reqValid(reqValid), .reqGrant(reqGrant), .reqReject(reqReject),
  .walkErase(walkErase), .walkDone(walkDone), .walkBusy(walkBusy),
  .wpOn(wpOn)
);

// File: tb/flash_lock_guard_bench.sv
`timescale 1ns/1ps
module flash_lock_guard_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [18:0] cmdAddr = '0;
  logic        reqValid = 1'b0;
  logic        reqErase = 1'b0;
  logic [18:0] reqAddr = '0;
  logic        reqGrant, reqReject, walkErase, walkDone, walkBusy;
  logic [4:0]  walkBlk;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [31:0] erasedMask;
  int          lastBlk;
  bit          orderBad, doneSeen, extraBad;

  always #4 clk = ~clk;

  flash_lock_guard u_flash_lock_guard (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .reqValid(reqValid), .reqErase(reqErase),
    .reqAddr(reqAddr), .reqGrant(reqGrant), .reqReject(reqReject),
    .walkErase(walkErase), .walkBlk(walkBlk), .walkDone(walkDone),
    .walkBusy(walkBusy)
  );

  // walk monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (walkErase) begin
      if (doneSeen) extraBad = 1'b1;
      if (int'(walkBlk) <= lastBlk) orderBad = 1'b1;
      lastBlk = int'(walkBlk);
      erasedMask[walkBlk] = 1'b1;
    end
    if (walkDone) begin
      if (walkBlk != 5'd31) orderBad = 1'b1;
      doneSeen = 1'b1;
    end
  end

  function automatic logic [18:0] addrOf(int blk, int off);
    return 19'((blk << 14) | (off & 16'h3FFF));
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doCmd(logic [1:0] op, int blk);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = addrOf(blk, 16'h0ABC);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic doReq(bit erase, logic [18:0] addr, bit expGrant, string req);
    @(negedge clk);
    reqValid = 1'b1; reqErase = erase; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqGrant == expGrant && reqReject == !expGrant, req,
          "grant/reject", {reqGrant, reqReject}, {expGrant, !expGrant});
  endtask

  task automatic t_reset;
    check(!reqGrant && !reqReject, "R1", "idle answer lines", {reqGrant, reqReject}, 0);
    check(!walkBusy && !walkErase && !walkDone, "R1", "walk idle",
          {walkBusy, walkErase, walkDone}, 0);
    @(negedge clk);
    check(!reqGrant && !reqReject, "R2", "no request, no answer", {reqGrant, reqReject}, 0);
    doReq(1'b0, addrOf(0, 0), 1'b1, "R1");
    doReq(1'b1, addrOf(31, 16'h3FFF), 1'b1, "R1");
  endtask

  task automatic t_lock_basic;
    doCmd(2'd0, 7);
    doCmd(2'd1, 0);
    doReq(1'b0, addrOf(7, 16'h0001), 1'b0, "R4");
    doReq(1'b1, addrOf(7, 16'h3FFF), 1'b0, "R4");
    doReq(1'b0, addrOf(7, 0), 1'b0, "R7"); // rejected erase kept lock
    doReq(1'b0, addrOf(8, 0), 1'b1, "R3");
    doReq(1'b0, addrOf(6, 16'h3FFF), 1'b1, "R3");
  endtask

  task automatic t_wp_toggle;
    doCmd(2'd2, 0);
    doReq(1'b0, addrOf(7, 16'h0100), 1'b1, "R5");
    doCmd(2'd1, 0);
    doReq(1'b0, addrOf(7, 16'h0100), 1'b0, "R6");
  endtask

  task automatic t_erase_clears;
    doCmd(2'd2, 0);
    doReq(1'b1, addrOf(7, 0), 1'b1, "R7");
    doCmd(2'd1, 0);
    doReq(1'b0, addrOf(7, 0), 1'b1, "R7");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd0; cmdAddr = addrOf(9, 16'h0010);
    reqValid = 1'b1; reqErase = 1'b1; reqAddr = addrOf(9, 16'h2000);
    @(negedge clk);
    cmdValid = 1'b0; reqValid = 1'b0;
    check(reqGrant && !reqReject, "R11", "erase judged on prior state",
          {reqGrant, reqReject}, 2'b10);
    doReq(1'b0, addrOf(9, 0), 1'b0, "R11");
  endtask

  task automatic runWalk(logic [31:0] expMask, bit disturb, string req);
    erasedMask = '0; lastBlk = -1; orderBad = 0; doneSeen = 0; extraBad = 0;
    doCmd(2'd3, 0);
    check(walkBusy, req, "busy after start", walkBusy, 1);
    if (disturb) begin
      reqValid = 1'b1; reqErase = 1'b0; reqAddr = addrOf(4, 0);
      @(negedge clk);
      reqValid = 1'b0;
      check(reqReject && !reqGrant, "R10", "request during walk",
            {reqGrant, reqReject}, 2'b01);
      cmdValid = 1'b1; cmdOp = 2'd0; cmdAddr = addrOf(4, 0);
      @(negedge clk);
      cmdValid = 1'b0;
    end
    for (int i = 0; i < 64 && !doneSeen; i++) @(negedge clk);
    @(negedge clk);
    check(doneSeen, req, "done seen", doneSeen, 1);
    check(!walkBusy, req, "busy cleared", walkBusy, 0);
    check(erasedMask == expMask, req, "erased blocks", erasedMask, expMask);
    check(!orderBad && !extraBad, "R8", "ascending single pass",
          {orderBad, extraBad}, 0);
  endtask

  task automatic t_walk_protected;
    doCmd(2'd0, 0);
    doCmd(2'd0, 31);
    runWalk(~32'h8000_0201, 1'b1, "R8");
    doReq(1'b0, addrOf(4, 0), 1'b1, "R10"); // lock during walk ignored
    doReq(1'b0, addrOf(0, 0), 1'b0, "R9");
    doReq(1'b0, addrOf(31, 0), 1'b0, "R9");
    doReq(1'b0, addrOf(9, 0), 1'b0, "R9");
  endtask

  task automatic t_walk_open;
    doCmd(2'd2, 0);
    runWalk(32'hFFFF_FFFF, 1'b0, "R9");
    doCmd(2'd1, 0);
    doReq(1'b0, addrOf(0, 0), 1'b1, "R9");
    doReq(1'b0, addrOf(9, 0), 1'b1, "R9");
    doReq(1'b0, addrOf(31, 0), 1'b1, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock_basic();
    t_wp_toggle();
    t_erase_clears();
    t_same_cycle();
    t_walk_protected();
    t_walk_open();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule